// File: doc/BRIEF.md
# Fractional Reference Clock Divider

This block produces a programmable reference clock from one of several source clocks. All sources live in a single fast clock domain and are modelled as one-cycle enable strobes. The selected strobe stream is divided by twice an integer divisor plus a fraction in steps of 1/512. The fraction comes from a 9-bit phase accumulator that lengthens individual half periods by one source tick. Two independent controls gate the result: one runs the generator and one drives the pin.

Software programs the block through a small word-addressed register window with two registers, control and trim. Each register has a plain write address, a write-one-to-clear alias and a write-one-to-set alias, so single bits can be flipped without read-modify-write. A new divisor or trim value is not used as soon as it is written. Software raises a switch request bit, and hardware clears that bit once the new pair is in use. This way a divide ratio change never cuts a half period short.

Top module: `refclk_gen`

## Requirements
- R1: After reset both registers read zero and `ref_out` is low.
- R2: The control register sits at address 0x00 and the trim register at 0x10. Adding 0x4 to either address gives its write-one-to-clear alias, adding 0x8 gives its write-one-to-set alias, and a write at +0x0 replaces the value. Control fields: source select [3:0], running status [8], switch request [9], pin enable [12], run [15], divisor [30:16]. The trim field is [31:23]. All other bits read 0.
- R3: Status bit 8 is read-only. It reads 1 from the second cycle after run is set and 0 from the second cycle after run is cleared.
- R4: Switch bit 9 is set by software only, through a plain write or the set alias. Writing 0 to it and the clear alias leave it unchanged. Hardware clears it when the pending divisor and trim are taken: on the next cycle if the generator is stopped or in bypass, otherwise at the next half-period boundary.
- R5: A written divisor or trim value has no effect on the output until the switch request is honoured.
- R6: With trim 0 and divisor N>0, `ref_out` stays high for N ticks of the selected source and low for N ticks.
- R7: With trim T, each half-period boundary adds T to a 9-bit accumulator. A carry lengthens the next half period by one tick. For example, divisor 2 with trim 256 settles into alternating half periods of 2 and 3 ticks. Divisor 1 with trim 511 gives half periods of 2 ticks almost always.
- R8: A divisor of 0 is bypass: `ref_out` follows the selected source strobe with a delay of one cycle.
- R9: Source code 0 selects `sys_tick`, code 7 selects `pll_tick` and code 8 selects `ext_tick`. Any other code supplies no ticks, so the output holds its level.
- R10: When run is cleared, `ref_out` goes low and the half-period counter, the accumulator and the phase reset. After run is set again with divisor N, the first rising edge comes after exactly N ticks.
- R11: When the pin enable is cleared, `ref_out` is low but the divider keeps running. When the pin enable is set again, the half periods are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for the whole block |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte address (selects the register and the alias) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the register that `addr` selects |
| sys_tick | input | 1 | System clock source strobe (code 0) |
| pll_tick | input | 1 | PLL clock source strobe (code 7) |
| ext_tick | input | 1 | External reference input strobe (code 8) |
| ref_out | output | 1 | Divided reference clock output |

## Verification
The hardest state to reach is a switch request that stays pending while the generator runs. With any live source, a boundary arrives within a few ticks and the bit clears before the bench can probe it. The bench therefore points the select field at an unused code so that the counter freezes in mid half period. It then raises the switch bit and shows that a zero write and a clear-alias write leave the bit set. Finally it restores a live source and watches the bit clear and the new divisor take over. The fractional cases are checked through run-length sums taken after the accumulator has settled, not through a fixed phase.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
   localparam int REG_W    = 32;
   localparam int SEL_W    = 4;
   localparam int STAT_BIT = 8;
   localparam int SW_BIT   = 9;
   localparam int OE_BIT   = 12;
   localparam int ON_BIT   = 15;
   localparam int DIV_LSB  = 16;
   localparam int TRIM_LSB = 23;

   typedef enum logic [1:0] {
      OP_WRITE = 2'd0,
      OP_CLR   = 2'd1,
      OP_SET   = 2'd2,
      OP_NONE  = 2'd3
   } reg_op_e;

   function automatic logic [REG_W-1:0] apply_op(reg_op_e op, logic [REG_W-1:0] old_v,
                                                logic [REG_W-1:0] wd);
      case (op)
         OP_WRITE: apply_op = wd;
         OP_CLR:   apply_op = old_v & ~wd;
         OP_SET:   apply_op = old_v | wd;
         default:  apply_op = old_v;
      endcase
   endfunction
endpackage

// File: rtl/refclk_regs.sv
module refclk_regs
   import refclk_pkg::*;
#(
   parameter int DIV_W  = 15,
   parameter int TRIM_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [4:0]        addr,
   input  logic [REG_W-1:0]  wdata,
   input  logic              sw_done,
   input  logic              active,
   output logic [REG_W-1:0]  rdata,
   output logic [SEL_W-1:0]  sel,
   output logic              on,
   output logic              oe,
   output logic              sw_req,
   output logic [DIV_W-1:0]  div,
   output logic [TRIM_W-1:0] trim
);
   localparam logic [REG_W-1:0] DIV_MASK  = REG_W'(((64'd1 << DIV_W) - 1) << DIV_LSB);
   localparam logic [REG_W-1:0] TRIM_MASK = REG_W'(((64'd1 << TRIM_W) - 1) << TRIM_LSB);
   localparam logic [REG_W-1:0] CTRL_MASK = DIV_MASK | (REG_W'(1) << ON_BIT)
                                          | (REG_W'(1) << OE_BIT) | REG_W'((1 << SEL_W) - 1);

   logic [REG_W-1:0] ctrl_q, trim_q;
   logic             req_q;
   reg_op_e          op;
   logic             hit_ctrl, hit_trim, sw_set;

   always_comb begin
      case (addr[3:2])
         2'd0:    op = OP_WRITE;
         2'd1:    op = OP_CLR;
         2'd2:    op = OP_SET;
         default: op = OP_NONE;
      endcase
   end

   assign hit_ctrl = wr_en && !addr[4];
   assign hit_trim = wr_en &&  addr[4];
   assign sw_set   = hit_ctrl && wdata[SW_BIT] && (op == OP_WRITE || op == OP_SET);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         trim_q <= '0;
         req_q  <= 1'b0;
      end else begin
         if (hit_ctrl) ctrl_q <= apply_op(op, ctrl_q, wdata) & CTRL_MASK;
         if (hit_trim) trim_q <= apply_op(op, trim_q, wdata) & TRIM_MASK;
         req_q <= (req_q && !sw_done) || sw_set;
      end
   end

   assign sel    = ctrl_q[SEL_W-1:0];
   assign on     = ctrl_q[ON_BIT];
   assign oe     = ctrl_q[OE_BIT];
   assign div    = ctrl_q[DIV_LSB +: DIV_W];
   assign trim   = trim_q[TRIM_LSB +: TRIM_W];
   assign sw_req = req_q;

   always_comb begin
      rdata = addr[4] ? trim_q : ctrl_q;
      if (!addr[4]) begin
         rdata[SW_BIT]   = req_q;
         rdata[STAT_BIT] = active;
      end
   end
endmodule

// File: rtl/refclk_srcsel.sv
module refclk_srcsel
   import refclk_pkg::*;
#(
   parameter int          CODE_SYS = 0,
   parameter int          CODE_PLL = 7,
   parameter int          CODE_EXT = 8,
   parameter bit          HAS_EXT  = 1'b1
) (
   input  logic [SEL_W-1:0] sel,
   input  logic             sys_tick,
   input  logic             pll_tick,
   input  logic             ext_tick,
   output logic             tick
);
   logic ext_hit;

   generate
      if (HAS_EXT) begin : g_ext
         assign ext_hit = (sel == SEL_W'(CODE_EXT)) && ext_tick;
      end else begin : g_no_ext
         assign ext_hit = 1'b0;
      end
   endgenerate

   assign tick = ((sel == SEL_W'(CODE_SYS)) && sys_tick)
              || ((sel == SEL_W'(CODE_PLL)) && pll_tick)
              || ext_hit;
endmodule

// File: rtl/refclk_fracdiv.sv
module refclk_fracdiv #(
   parameter int DIV_W  = 15,
   parameter int TRIM_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              on,
   input  logic              tick,
   input  logic              sw_req,
   input  logic [DIV_W-1:0]  div_new,
   input  logic [TRIM_W-1:0] trim_new,
   output logic              phase,
   output logic              active,
   output logic              sw_done,
   output logic [DIV_W-1:0]  div_act,
   output logic [DIV_W:0]    cnt
);
   logic [TRIM_W-1:0] trim_act, acc;
   logic              stretch;
   logic [DIV_W:0]    last_cnt;
   logic              bypass, boundary;

   assign bypass   = (div_act == '0);
   assign last_cnt = {1'b0, div_act} + (DIV_W+1)'(stretch) - (DIV_W+1)'(1);
   assign boundary = on && !bypass && tick && (cnt == last_cnt);
   assign sw_done  = sw_req && (boundary || !on || bypass);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_act  <= '0;
         trim_act <= '0;
         cnt      <= '0;
         acc      <= '0;
         stretch  <= 1'b0;
         phase    <= 1'b0;
         active   <= 1'b0;
      end else begin
         active <= on;
         if (!on) begin
            cnt     <= '0;
            acc     <= '0;
            stretch <= 1'b0;
            phase   <= 1'b0;
         end else if (bypass) begin
            phase <= tick;
            cnt   <= '0;
         end else if (tick) begin
            if (boundary) begin
               phase          <= !phase;
               cnt            <= '0;
               {stretch, acc} <= {1'b0, acc} + {1'b0, trim_act};
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         if (sw_done) begin
            div_act  <= div_new;
            trim_act <= trim_new;
         end
      end
   end
endmodule

// File: rtl/refclk_gen.sv
module refclk_gen
   import refclk_pkg::*;
#(
   parameter int DIV_W    = 15,
   parameter int TRIM_W   = 9,
   parameter int CODE_SYS = 0,
   parameter int CODE_PLL = 7,
   parameter int CODE_EXT = 8,
   parameter bit HAS_EXT  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [4:0]  addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   input  logic        sys_tick,
   input  logic        pll_tick,
   input  logic        ext_tick,
   output logic        ref_out
);
   generate
      if (DIV_W < 1 || DIV_W > 15) begin : g_bad_div
         $error("DIV_W must lie in 1..15");
      end
      if (TRIM_W < 1 || TRIM_W > 9) begin : g_bad_trim
         $error("TRIM_W must lie in 1..9");
      end
   endgenerate

   logic [SEL_W-1:0]  sel_w;
   logic              on_w, oe_w, req_w, sw_done_w, active_w, tick_w, phase_w;
   logic [DIV_W-1:0]  div_w, div_act_w;
   logic [TRIM_W-1:0] trim_w;
   logic [DIV_W:0]    cnt_w;

   refclk_regs #(.DIV_W(DIV_W), .TRIM_W(TRIM_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .sw_done(sw_done_w), .active(active_w), .rdata(rdata), .sel(sel_w),
      .on(on_w), .oe(oe_w), .sw_req(req_w), .div(div_w), .trim(trim_w)
   );

   refclk_srcsel #(.CODE_SYS(CODE_SYS), .CODE_PLL(CODE_PLL), .CODE_EXT(CODE_EXT),
                   .HAS_EXT(HAS_EXT)) u_src (
      .sel(sel_w), .sys_tick(sys_tick), .pll_tick(pll_tick), .ext_tick(ext_tick),
      .tick(tick_w)
   );

   refclk_fracdiv #(.DIV_W(DIV_W), .TRIM_W(TRIM_W)) u_div (
      .clk(clk), .rst_n(rst_n), .on(on_w), .tick(tick_w), .sw_req(req_w),
      .div_new(div_w), .trim_new(trim_w), .phase(phase_w), .active(active_w),
      .sw_done(sw_done_w), .div_act(div_act_w), .cnt(cnt_w)
   );

   assign ref_out = phase_w && oe_w && on_w;
endmodule

// File: rtl/refclk_gen_chk.sv
module refclk_gen_chk #(
   parameter int DIV_W = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             on,
   input logic             oe,
   input logic             req,
   input logic             sw_done,
   input logic             active,
   input logic             ref_out,
   input logic [DIV_W-1:0] div_act,
   input logic [DIV_W:0]   cnt
);
   // R10
   off_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !on |=> !ref_out);
   // R11
   pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) !oe |-> !ref_out);
   // R5
   div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                                  !sw_done |=> $stable(div_act));
   // R3
   status_on_chk: assert property (@(posedge clk) disable iff (!rst_n) on |=> active);
   // R3
   status_off_chk: assert property (@(posedge clk) disable iff (!rst_n) !on |=> !active);
   // R4
   req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                                   $fell(req) |-> $past(sw_done));
   // R7
   half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
                                  (on && div_act != '0) |-> (cnt <= {1'b0, div_act}));
endmodule

bind refclk_gen refclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .on(on_w), .oe(oe_w), .req(req_w), .sw_done(sw_done_w),
   .active(active_w), .ref_out(ref_out), .div_act(div_act_w), .cnt(cnt_w)
);

// File: tb/refclk_gen_test.sv
module refclk_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        sys_tick = 1'b1;
   logic        pll_tick = 1'b0;
   logic        ext_tick = 1'b0;
   logic        ref_out;

   int total = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 1'b0;
   int runs [32];

   refclk_gen uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .sys_tick(sys_tick), .pll_tick(pll_tick), .ext_tick(ext_tick), .ref_out(ref_out)
   );

   always #5 clk = ~clk;

   always @(negedge clk) begin
      cyc++;
      pll_tick <= (cyc % 2 == 0);
      ext_tick <= (cyc % 3 == 0);
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic wait_sw(input string req);
      logic [31:0] v;
      int n = 0;
      bus_rd(5'h00, v);
      while (v[9] && n < 50) begin
         @(negedge clk); n++; bus_rd(5'h00, v);
      end
      chk(!v[9], req, v[9], 0);
   endtask

   task automatic capture(input int skip, input int n);
      logic prev;
      int len;
      int waited = 0;
      prev = ref_out;
      while (ref_out == prev && waited < 3000) begin @(negedge clk); waited++; end
      for (int r = 0; r < skip + n; r++) begin
         prev = ref_out; len = 0;
         while (ref_out == prev && len < 3000) begin @(negedge clk); len++; end
         if (r >= skip) runs[r-skip] = len;
      end
   endtask

   task automatic runs_equal(input int n, input int exp, input string req);
      for (int i = 0; i < n; i++) chk(runs[i] == exp, req, runs[i], exp);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      bus_rd(5'h00, v); chk(v == 0, "R1 ctrl", v, 0);
      bus_rd(5'h10, v); chk(v == 0, "R1 trim", v, 0);
      chk(ref_out == 0, "R1 ref_out", ref_out, 0);
   endtask

   task automatic t_regmap;
      logic [31:0] v;
      bus_wr(5'h00, 32'h0005_1003);
      bus_rd(5'h00, v); chk(v == 32'h0005_1003, "R2 plain", v, 32'h0005_1003);
      bus_wr(5'h04, 32'h0000_1001);
      bus_rd(5'h00, v); chk(v == 32'h0005_0002, "R2 clr", v, 32'h0005_0002);
      bus_wr(5'h08, 32'h8000_1000);
      bus_rd(5'h00, v); chk(v == 32'h0005_1002, "R2 set", v, 32'h0005_1002);
      bus_wr(5'h10, 32'hFFFF_FFFF);
      bus_rd(5'h10, v); chk(v == 32'hFF80_0000, "R2 trim", v, 32'hFF80_0000);
      bus_wr(5'h14, 32'h8000_0000);
      bus_rd(5'h10, v); chk(v == 32'h7F80_0000, "R2 trim clr", v, 32'h7F80_0000);
      bus_wr(5'h00, 0); bus_wr(5'h10, 0);
   endtask

   task automatic t_status;
      logic [31:0] v;
      bus_wr(5'h00, 32'h0000_0100);
      bus_rd(5'h00, v); chk(v == 0, "R3 read-only", v, 0);
      bus_wr(5'h08, 32'h0000_0200);
      @(negedge clk);
      bus_rd(5'h00, v); chk(v[9] == 0, "R4 stopped clears", v[9], 0);
      bus_wr(5'h08, 32'h0000_8000);
      @(negedge clk);
      bus_rd(5'h00, v); chk(v[8] == 1, "R3 running", v[8], 1);
      bus_wr(5'h04, 32'h0000_8000);
      @(negedge clk);
      bus_rd(5'h00, v); chk(v[8] == 0, "R3 stopped", v[8], 0);
   endtask

   task automatic t_integer;
      bus_wr(5'h10, 0);
      bus_wr(5'h00, 32'h0003_9200);
      wait_sw("R4 switch");
      capture(2, 6); runs_equal(6, 3, "R6 div3");
   endtask

   task automatic t_noswitch;
      bus_wr(5'h00, 32'h0005_9000);
      capture(1, 6); runs_equal(6, 3, "R5 no switch");
      bus_wr(5'h08, 32'h0000_0200);
      wait_sw("R4 set alias");
      capture(2, 6); runs_equal(6, 5, "R5 after switch");
   endtask

   task automatic t_frac;
      int sum = 0;
      bit ok = 1'b1;
      bus_wr(5'h10, 32'h8000_0000);
      bus_wr(5'h00, 32'h0002_9200);
      wait_sw("R7 switch");
      capture(4, 8);
      for (int i = 0; i < 8; i++) begin
         sum += runs[i];
         if (runs[i] != 2 && runs[i] != 3) ok = 1'b0;
      end
      chk(ok, "R7 run set", runs[0], 2);
      chk(sum == 20, "R7 sum", sum, 20);
      bus_wr(5'h10, 32'hFF80_0000);
      bus_wr(5'h00, 32'h0001_9200);
      wait_sw("R7 switch max");
      capture(4, 8); runs_equal(8, 2, "R7 trim max");
   endtask

   task automatic t_oe;
      bit low = 1'b1;
      bus_wr(5'h10, 0);
      bus_wr(5'h00, 32'h0003_9200);
      wait_sw("R11 switch");
      bus_wr(5'h04, 32'h0000_1000);
      for (int i = 0; i < 30; i++) begin
         if (ref_out) low = 1'b0;
         @(negedge clk);
      end
      chk(low, "R11 pin low", !low, 0);
      bus_wr(5'h08, 32'h0000_1000);
      capture(1, 6); runs_equal(6, 3, "R11 kept running");
   endtask

   task automatic t_src;
      bit steady = 1'b1;
      logic lvl;
      bus_wr(5'h00, 32'h0002_9207);
      wait_sw("R9 switch");
      capture(2, 6); runs_equal(6, 4, "R9 pll");
      bus_wr(5'h00, 32'h0002_9008);
      capture(2, 6); runs_equal(6, 6, "R9 ext");
      bus_wr(5'h00, 32'h0002_9005);
      repeat (3) @(negedge clk);
      lvl = ref_out;
      for (int i = 0; i < 40; i++) begin
         if (ref_out != lvl) steady = 1'b0;
         @(negedge clk);
      end
      chk(steady, "R9 unused code holds", !steady, 0);
   endtask

   task automatic t_pending;
      logic [31:0] v;
      bus_wr(5'h00, 32'h0004_9205);
      repeat (20) @(negedge clk);
      bus_rd(5'h00, v); chk(v[9] == 1, "R4 pending", v[9], 1);
      bus_wr(5'h04, 32'h0000_0200);
      bus_rd(5'h00, v); chk(v[9] == 1, "R4 clr alias ignored", v[9], 1);
      bus_wr(5'h00, 32'h0004_9005);
      bus_rd(5'h00, v); chk(v[9] == 1, "R4 zero write ignored", v[9], 1);
      bus_wr(5'h04, 32'h0000_0005);
      wait_sw("R4 boundary clear");
      capture(2, 6); runs_equal(6, 4, "R4 new divisor");
   endtask

   task automatic t_bypass;
      bit high = 1'b1;
      bus_wr(5'h00, 32'h0000_9200);
      wait_sw("R8 switch");
      repeat (2) @(negedge clk);
      for (int i = 0; i < 10; i++) begin
         if (!ref_out) high = 1'b0;
         @(negedge clk);
      end
      chk(high, "R8 sys bypass", high, 1);
      bus_wr(5'h00, 32'h0000_9007);
      capture(2, 8); runs_equal(8, 1, "R8 pll bypass");
   endtask

   task automatic t_off;
      bit low = 1'b1;
      int n = 0;
      bus_wr(5'h04, 32'h0000_8000);
      for (int i = 0; i < 20; i++) begin
         if (ref_out) low = 1'b0;
         @(negedge clk);
      end
      chk(low, "R10 off low", !low, 0);
      bus_wr(5'h00, 32'h0003_1200);
      @(negedge clk);
      bus_wr(5'h08, 32'h0000_8000);
      while (!ref_out && n < 50) begin @(negedge clk); n++; end
      chk(n == 3, "R10 restart delay", n, 3);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_regmap;
      t_status;
      t_integer;
      t_noswitch;
      t_frac;
      t_oe;
      t_src;
      t_pending;
      t_bypass;
      t_off;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; fails++;
         $display("FAIL watchdog actual=%0d expected=0", cyc);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule